// File: doc/BRIEF.md
# Command and Receive Unit Controller

This block is the control core behind a host-visible control block for a network adapter. It runs two independent engines. The command engine walks a chain of command descriptors. The receive engine fills a chain of receive descriptors. Memory traffic and descriptor contents are outside the block. Each engine talks to the outside through a request line, a descriptor index and a completion input.

A single host write strobe carries four things: a control code for each engine, a start pointer, a write-one-to-clear acknowledge mask for the interrupt causes, and an interrupt mask bit. The engine states, the cause bits and the interrupt line are registered outputs, so the host can read the whole block back at any time. Descriptor completions update the state and the causes, and advance each engine to its next descriptor on its own. A software reset of the chip maps onto the synchronous reset, and the host must then start each engine again.

The control code is two bits: 0 is no-op, 1 is start, 2 is resume, and 3 is stop. The stop code is qualified by a halt bit: 0 means suspend and 1 means go idle. Command engine states are 0 idle, 1 active and 2 suspended. Receive engine states are 0 idle, 1 ready, 2 suspended and 3 out-of-descriptors.

Top module: `cmdrx_ctrl`

## Requirements
- R1: After reset both engines are idle (state 0), both request lines are low, both indices are 0, all four cause bits are clear and irq is low.
- R2: A host write with code 1 for an engine puts it, on the next cycle, into its running state (command state 1, receive state 1). Its index equals the written pointer and its request is high. This applies from any state and drops any pending stop.
- R3: While the command engine is active, a completion without the last flag increments cu_idx by one modulo 2^IDX_W, and the engine stays active.
- R4: While the command engine is active, a completion with the last flag returns it to idle (state 0) and sets cause bit 0.
- R5: A code 3 with halt 0, written while an engine is running, takes effect only at that engine's next completion. At that completion the index still advances and the engine enters state 2. For the command engine, cause bit 1 is also set.
- R6: A code 3 with halt 1 sends a running engine to idle at its next completion, and a suspended or out-of-descriptors engine to idle on the next cycle.
- R7: Resume (code 2) moves a suspended engine back to its running state at its held index. Resume in the idle state has no effect on state or request.
- R8: While the receive engine is ready, a frame completion sets cause bit 2 and increments ru_idx by one.
- R9: A frame completion with the end-of-list flag moves the receive engine to state 3. It sets cause bits 2 and 3, keeps ru_idx and drops ru_req. In state 3, resume and suspend-without-halt have no effect.
- R10: Cause bits are sticky. A host write clears each bit whose ack bit is 1, except that a new cause in the same cycle wins. irq is high when any cause bit is set and the latched mask bit is 0.
- R11: When a host write carries a nonzero code for an engine, that code is applied, and a completion arriving for that engine in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe to the control block |
| host_cu_code | input | 2 | Command engine control code |
| host_cu_halt | input | 1 | Qualifies code 3 for the command engine: 1 idle, 0 suspend |
| host_ru_code | input | 2 | Receive engine control code |
| host_ru_halt | input | 1 | Qualifies code 3 for the receive engine |
| host_ptr | input | IDX_W | Start pointer for code 1 |
| host_ack | input | 4 | Write-one-to-clear mask for the cause bits |
| host_mask | input | 1 | Interrupt mask, latched on each write |
| cu_req | output | 1 | Command engine requests the descriptor at cu_idx |
| cu_idx | output | IDX_W | Current command descriptor index |
| cu_done | input | 1 | Current command descriptor completed |
| cu_last | input | 1 | Completed descriptor was the last of the chain |
| ru_req | output | 1 | Receive engine ready for a frame into ru_idx |
| ru_idx | output | IDX_W | Current receive descriptor index |
| ru_frame | input | 1 | A frame was stored into the current descriptor |
| ru_eol | input | 1 | That descriptor was the last free one |
| cu_state | output | 2 | Command engine state |
| ru_state | output | 2 | Receive engine state |
| cause | output | 4 | Sticky interrupt causes |
| irq | output | 1 | Interrupt request |

## Verification
Every output is a register, or a simple function of registers, that changes on the edge after the stimulus. So a wrong next state, a lost pending stop or a mis-stepped index shows at cu_state, ru_state or the index ports on the very next sample. A wrong cause update shows at cause and irq in that same cycle. A deferred stop that fires early or late shows as a state mismatch at the completion cycle, not later. Random mixes of writes and completions that land in the same cycle exercise the precedence rule, which fixed sequences alone would rarely reach.

// File: rtl/cmdrx_pkg.sv
package cmdrx_pkg;
  localparam int NCAUSE = 4;
  localparam int C_CU_END  = 0;
  localparam int C_CU_STOP = 1;
  localparam int C_RU_FRM  = 2;
  localparam int C_RU_NORES = 3;

  localparam logic [1:0] CTL_NOP  = 2'd0;
  localparam logic [1:0] CTL_ACT  = 2'd1;
  localparam logic [1:0] CTL_RES  = 2'd2;
  localparam logic [1:0] CTL_STOP = 2'd3;

  typedef enum logic [1:0] {
    CU_IDLE   = 2'd0,
    CU_ACTIVE = 2'd1,
    CU_SUSP   = 2'd2
  } cu_st_e;

  typedef enum logic [1:0] {
    RU_IDLE  = 2'd0,
    RU_READY = 2'd1,
    RU_SUSP  = 2'd2,
    RU_NORES = 2'd3
  } ru_st_e;
endpackage

// File: rtl/cmdrx_cu_fsm.sv
module cmdrx_cu_fsm
  import cmdrx_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [1:0]       code,
  input  logic             halt,
  input  logic [IDX_W-1:0] ptr,
  input  logic             done,
  input  logic             last,
  output cu_st_e           state,
  output logic [IDX_W-1:0] idx,
  output logic             req,
  output logic             set_end,
  output logic             set_stop
);
  cu_st_e           st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             pend_q, pend_d, halt_q, halt_d;
  logic             cmd;

  assign cmd = wr && (code != CTL_NOP);

  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    pend_d   = pend_q;
    halt_d   = halt_q;
    set_end  = 1'b0;
    set_stop = 1'b0;
    if (cmd) begin
      case (code)
        CTL_ACT: begin
          st_d   = CU_ACTIVE;
          idx_d  = ptr;
          pend_d = 1'b0;
        end
        CTL_RES: if (st_q == CU_SUSP) st_d = CU_ACTIVE;
        default: begin
          if (st_q == CU_ACTIVE) begin
            pend_d = 1'b1;
            halt_d = halt;
          end else if (st_q == CU_SUSP && halt) begin
            st_d = CU_IDLE;
          end
        end
      endcase
    end else if (st_q == CU_ACTIVE && done) begin
      if (last) begin
        st_d    = CU_IDLE;
        pend_d  = 1'b0;
        set_end = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
        if (pend_q) begin
          st_d     = halt_q ? CU_IDLE : CU_SUSP;
          pend_d   = 1'b0;
          set_stop = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= CU_IDLE;
      idx_q  <= '0;
      pend_q <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      pend_q <= pend_d;
      halt_q <= halt_d;
    end
  end

  assign state = st_q;
  assign idx   = idx_q;
  assign req   = (st_q == CU_ACTIVE);

  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    wr && code == CTL_ACT |=> st_q == CU_ACTIVE && idx_q == $past(ptr));
  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    req && done && !last && !cmd |=> idx_q == IDX_W'($past(idx_q) + 1'b1));
  p_end_idle_r4: assert property (@(posedge clk) disable iff (rst)
    req && done && last && !cmd |=> st_q == CU_IDLE);
  p_resume_idle_r7: assert property (@(posedge clk) disable iff (rst)
    wr && code == CTL_RES && st_q == CU_IDLE |=> st_q == CU_IDLE);
endmodule

// File: rtl/cmdrx_ru_fsm.sv
module cmdrx_ru_fsm
  import cmdrx_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [1:0]       code,
  input  logic             halt,
  input  logic [IDX_W-1:0] ptr,
  input  logic             frame,
  input  logic             eol,
  output ru_st_e           state,
  output logic [IDX_W-1:0] idx,
  output logic             req,
  output logic             set_frm,
  output logic             set_nores
);
  ru_st_e           st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             pend_q, pend_d, halt_q, halt_d;
  logic             cmd;

  assign cmd = wr && (code != CTL_NOP);

  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    pend_d    = pend_q;
    halt_d    = halt_q;
    set_frm   = 1'b0;
    set_nores = 1'b0;
    if (cmd) begin
      case (code)
        CTL_ACT: begin
          st_d   = RU_READY;
          idx_d  = ptr;
          pend_d = 1'b0;
        end
        CTL_RES: if (st_q == RU_SUSP) st_d = RU_READY;
        default: begin
          if (st_q == RU_READY) begin
            pend_d = 1'b1;
            halt_d = halt;
          end else if ((st_q == RU_SUSP || st_q == RU_NORES) && halt) begin
            st_d = RU_IDLE;
          end
        end
      endcase
    end else if (st_q == RU_READY && frame) begin
      set_frm = 1'b1;
      if (eol) begin
        st_d      = RU_NORES;
        pend_d    = 1'b0;
        set_nores = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
        if (pend_q) begin
          st_d   = halt_q ? RU_IDLE : RU_SUSP;
          pend_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= RU_IDLE;
      idx_q  <= '0;
      pend_q <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      pend_q <= pend_d;
      halt_q <= halt_d;
    end
  end

  assign state = st_q;
  assign idx   = idx_q;
  assign req   = (st_q == RU_READY);

  p_frame_step_r8: assert property (@(posedge clk) disable iff (rst)
    req && frame && !eol && !cmd |=> idx_q == IDX_W'($past(idx_q) + 1'b1));
  p_nores_r9: assert property (@(posedge clk) disable iff (rst)
    req && frame && eol && !cmd |=> st_q == RU_NORES && $stable(idx_q));
  p_nores_hold_r9: assert property (@(posedge clk) disable iff (rst)
    st_q == RU_NORES && !(wr && (code == CTL_ACT || (code == CTL_STOP && halt)))
    |=> st_q == RU_NORES);
endmodule

// File: rtl/cmdrx_irq.sv
module cmdrx_irq
  import cmdrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [NCAUSE-1:0] ack,
  input  logic              mask_in,
  input  logic [NCAUSE-1:0] set,
  output logic [NCAUSE-1:0] cause,
  output logic              irq
);
  logic [NCAUSE-1:0] cause_q;
  logic              mask_q;

  for (genvar i = 0; i < NCAUSE; i++) begin : g_cause
    always_ff @(posedge clk) begin
      if (rst) cause_q[i] <= 1'b0;
      else     cause_q[i] <= set[i] | (cause_q[i] & ~(wr & ack[i]));
    end

    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> cause_q[i]);
    p_w1c_r10: assert property (@(posedge clk) disable iff (rst)
      wr && ack[i] && !set[i] |=> !cause_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst)     mask_q <= 1'b0;
    else if (wr) mask_q <= mask_in;
  end

  assign cause = cause_q;
  assign irq   = (|cause_q) & ~mask_q;
endmodule

// File: rtl/cmdrx_ctrl.sv
module cmdrx_ctrl
  import cmdrx_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_wr,
  input  logic [1:0]       host_cu_code,
  input  logic             host_cu_halt,
  input  logic [1:0]       host_ru_code,
  input  logic             host_ru_halt,
  input  logic [IDX_W-1:0] host_ptr,
  input  logic [3:0]       host_ack,
  input  logic             host_mask,
  output logic             cu_req,
  output logic [IDX_W-1:0] cu_idx,
  input  logic             cu_done,
  input  logic             cu_last,
  output logic             ru_req,
  output logic [IDX_W-1:0] ru_idx,
  input  logic             ru_frame,
  input  logic             ru_eol,
  output logic [1:0]       cu_state,
  output logic [1:0]       ru_state,
  output logic [3:0]       cause,
  output logic             irq
);
  cu_st_e            cu_st;
  ru_st_e            ru_st;
  logic [NCAUSE-1:0] set;

  cmdrx_cu_fsm #(.IDX_W(IDX_W)) u_cu (
    .clk(clk), .rst(rst), .wr(host_wr), .code(host_cu_code), .halt(host_cu_halt),
    .ptr(host_ptr), .done(cu_done), .last(cu_last), .state(cu_st), .idx(cu_idx),
    .req(cu_req), .set_end(set[C_CU_END]), .set_stop(set[C_CU_STOP])
  );

  cmdrx_ru_fsm #(.IDX_W(IDX_W)) u_ru (
    .clk(clk), .rst(rst), .wr(host_wr), .code(host_ru_code), .halt(host_ru_halt),
    .ptr(host_ptr), .frame(ru_frame), .eol(ru_eol), .state(ru_st), .idx(ru_idx),
    .req(ru_req), .set_frm(set[C_RU_FRM]), .set_nores(set[C_RU_NORES])
  );

  cmdrx_irq u_irq (
    .clk(clk), .rst(rst), .wr(host_wr), .ack(host_ack), .mask_in(host_mask),
    .set(set), .cause(cause), .irq(irq)
  );

  assign cu_state = cu_st;
  assign ru_state = ru_st;

  p_reset_r1: assert property (@(posedge clk) rst |=> cu_state == 2'd0 && ru_state == 2'd0 && cause == 4'd0);
  p_prec_r11: assert property (@(posedge clk) disable iff (rst)
    host_wr && host_cu_code == CTL_ACT && cu_done && cu_last |=> !cause[C_CU_END] || $past(cause[C_CU_END] && !host_ack[C_CU_END]));
endmodule

// File: tb/cmdrx_ctrl_tb.sv
module cmdrx_ctrl_tb;
  localparam int IDX_W = 8;
  localparam int IMASK = (1 << IDX_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr = 0, host_cu_halt = 0, host_ru_halt = 0, host_mask = 0;
  logic [1:0] host_cu_code = 0, host_ru_code = 0;
  logic [IDX_W-1:0] host_ptr = 0;
  logic [3:0] host_ack = 0;
  logic cu_done = 0, cu_last = 0, ru_frame = 0, ru_eol = 0;
  logic cu_req, ru_req, irq;
  logic [IDX_W-1:0] cu_idx, ru_idx;
  logic [1:0] cu_state, ru_state;
  logic [3:0] cause;

  int n_chk = 0, n_bad = 0;
  int m_cu, m_ru, m_cidx, m_ridx, m_cause, m_mask;
  bit m_cpend, m_chalt, m_rpend, m_rhalt;

  always #5 clk = ~clk;

  cmdrx_ctrl #(.IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_cu_code(host_cu_code),
    .host_cu_halt(host_cu_halt), .host_ru_code(host_ru_code), .host_ru_halt(host_ru_halt),
    .host_ptr(host_ptr), .host_ack(host_ack), .host_mask(host_mask),
    .cu_req(cu_req), .cu_idx(cu_idx), .cu_done(cu_done), .cu_last(cu_last),
    .ru_req(ru_req), .ru_idx(ru_idx), .ru_frame(ru_frame), .ru_eol(ru_eol),
    .cu_state(cu_state), .ru_state(ru_state), .cause(cause), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cu = 0; m_ru = 0; m_cidx = 0; m_ridx = 0; m_cause = 0; m_mask = 0;
    m_cpend = 0; m_chalt = 0; m_rpend = 0; m_rhalt = 0;
  endtask

  task automatic model_step();
    int setb = 0;
    if (host_wr && host_cu_code != 0) begin
      case (host_cu_code)
        2'd1: begin m_cu = 1; m_cidx = host_ptr; m_cpend = 0; end
        2'd2: if (m_cu == 2) m_cu = 1;
        default: if (m_cu == 1) begin m_cpend = 1; m_chalt = host_cu_halt; end
                 else if (m_cu == 2 && host_cu_halt) m_cu = 0;
      endcase
    end else if (m_cu == 1 && cu_done) begin
      if (cu_last) begin m_cu = 0; m_cpend = 0; setb |= 1; end
      else begin
        m_cidx = (m_cidx + 1) & IMASK;
        if (m_cpend) begin m_cu = m_chalt ? 0 : 2; m_cpend = 0; setb |= 2; end
      end
    end
    if (host_wr && host_ru_code != 0) begin
      case (host_ru_code)
        2'd1: begin m_ru = 1; m_ridx = host_ptr; m_rpend = 0; end
        2'd2: if (m_ru == 2) m_ru = 1;
        default: if (m_ru == 1) begin m_rpend = 1; m_rhalt = host_ru_halt; end
                 else if ((m_ru == 2 || m_ru == 3) && host_ru_halt) m_ru = 0;
      endcase
    end else if (m_ru == 1 && ru_frame) begin
      setb |= 4;
      if (ru_eol) begin m_ru = 3; m_rpend = 0; setb |= 8; end
      else begin
        m_ridx = (m_ridx + 1) & IMASK;
        if (m_rpend) begin m_ru = m_rhalt ? 0 : 2; m_rpend = 0; end
      end
    end
    if (host_wr) begin
      m_cause = m_cause & ~int'(host_ack);
      m_mask = host_mask;
    end
    m_cause = m_cause | setb;
  endtask

  task automatic quiet();
    host_wr = 0; host_cu_code = 0; host_ru_code = 0; host_cu_halt = 0; host_ru_halt = 0;
    host_ptr = 0; host_ack = 0; host_mask = 0;
    cu_done = 0; cu_last = 0; ru_frame = 0; ru_eol = 0;
  endtask

  task automatic compare_all();
    chk("R2 R4 R5 R6 R7 R11 cu_state", cu_state, m_cu);
    chk("R2 R5 R6 R7 R8 R9 ru_state", ru_state, m_ru);
    chk("R2 R3 R11 cu_idx", cu_idx, m_cidx);
    chk("R2 R8 R9 ru_idx", ru_idx, m_ridx);
    chk("R2 R7 cu_req", cu_req, m_cu == 1);
    chk("R2 R9 ru_req", ru_req, m_ru == 1);
    chk("R4 R5 R8 R9 R10 cause", cause, m_cause);
    chk("R10 irq", irq, (m_cause != 0) && (m_mask == 0));
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    quiet();
    compare_all();
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    compare_all();
    chk("R1 cu_state", cu_state, 0);
    chk("R1 irq", irq, 0);

    host_wr = 1; host_cu_code = 1; host_ptr = 5; tick();
    chk("R2 cu start state", cu_state, 1); chk("R2 cu start idx", cu_idx, 5);
    cu_done = 1; tick();
    chk("R3 cu step", cu_idx, 6);
    host_wr = 1; host_cu_code = 3; tick();
    chk("R5 deferred suspend", cu_state, 1);
    cu_done = 1; tick();
    chk("R5 suspended", cu_state, 2); chk("R5 idx advanced", cu_idx, 7);
    chk("R5 cause1", cause, 2); chk("R10 irq up", irq, 1);
    host_wr = 1; host_cu_code = 2; host_ack = 4'b0010; tick();
    chk("R7 resume", cu_state, 1); chk("R7 held idx", cu_idx, 7); chk("R10 w1c", cause, 0);
    cu_done = 1; cu_last = 1; tick();
    chk("R4 end idle", cu_state, 0); chk("R4 cause0", cause, 1);
    host_wr = 1; host_cu_code = 2; host_ack = 4'b0001; tick();
    chk("R7 resume in idle", cu_state, 0); chk("R7 req low", cu_req, 0);

    host_wr = 1; host_ru_code = 1; host_ptr = 250; tick();
    chk("R2 ru start", ru_state, 1); chk("R2 ru idx", ru_idx, 250);
    ru_frame = 1; tick();
    chk("R8 ru step", ru_idx, 251); chk("R8 cause2", cause, 4);
    ru_frame = 1; ru_eol = 1; tick();
    chk("R9 nores", ru_state, 3); chk("R9 req low", ru_req, 0);
    chk("R9 idx held", ru_idx, 251); chk("R9 causes", cause, 12);
    host_wr = 1; host_ru_code = 2; tick();
    chk("R9 resume ignored", ru_state, 3);
    host_wr = 1; host_ru_code = 3; host_ru_halt = 1; host_mask = 1; tick();
    chk("R6 nores to idle", ru_state, 0); chk("R10 masked", irq, 0);
    host_wr = 1; host_ru_code = 1; host_ptr = 0; ru_frame = 1; tick();
    chk("R11 frame ignored", ru_idx, 0); chk("R10 unmasked", irq, 1);
    host_wr = 1; host_ack = 4'b0100; ru_frame = 1; tick();
    chk("R10 set beats clear", cause, 12); chk("R8 step", ru_idx, 1);
    host_wr = 1; host_cu_code = 1; host_ptr = 3; tick();
    host_wr = 1; host_cu_code = 1; host_ptr = 9; cu_done = 1; cu_last = 1; tick();
    chk("R11 restart", cu_state, 1); chk("R11 idx", cu_idx, 9); chk("R11 no end cause", cause, 12);
    host_wr = 1; host_ru_code = 3; tick();
    ru_frame = 1; tick();
    chk("R5 ru suspended", ru_state, 2); chk("R5 ru idx", ru_idx, 2);
    host_wr = 1; host_cu_code = 3; host_cu_halt = 1; tick();
    cu_done = 1; tick();
    chk("R6 cu deferred idle", cu_state, 0);

    for (int k = 0; k < 3000; k++) begin
      host_wr = ($urandom_range(0, 3) == 0);
      host_cu_code = 2'($urandom_range(0, 3));
      host_ru_code = 2'($urandom_range(0, 3));
      host_cu_halt = 1'($urandom_range(0, 1));
      host_ru_halt = 1'($urandom_range(0, 1));
      host_ptr = IDX_W'($urandom_range(0, IMASK));
      host_ack = 4'($urandom_range(0, 15));
      host_mask = ($urandom_range(0, 3) == 0);
      cu_done = ($urandom_range(0, 2) == 0);
      cu_last = ($urandom_range(0, 7) == 0);
      ru_frame = ($urandom_range(0, 2) == 0);
      ru_eol = ($urandom_range(0, 7) == 0);
      tick();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule